// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block produces the integer feedback divide value that a fractional-N synthesizer's VCO counter uses for each comparison-clock period. The requested ratio is an integer part plus a signed two's-complement fraction. A third-order cascade of three first-order error-feedback accumulators, with the usual noise-cancelling recombination of their carries, turns that ratio into a stream of integers. The average of the stream equals the requested ratio, and the quantisation noise is pushed to high frequencies.

The register file presents live integer and fraction settings. It also raises a `commit` pulse when the byte holding the top fraction bits is written. Only that pulse copies both settings into the working (shadow) copy, so a partly written fraction is never used. The integer is clamped into the legal window at that moment, and a flag reports that the value asked for was out of range. Two controls force pure-integer output: `bypass` skips the modulator, and clearing `dither_en` treats the fraction as zero.

A three-state machine sets how the next tick is handled. The states are SHAPE (modulator active), FLAT (fraction treated as zero) and PASS (modulator bypassed). On every clock it takes the next state from the controls. From any state it goes to PASS when `bypass` is 1. It goes to FLAT when `bypass` is 0 and `dither_en` is 0. It goes to SHAPE when `bypass` is 0 and `dither_en` is 1. In FLAT and PASS the accumulators are held cleared, and a commit clears them as well.

Top module: `frac_ratio_mod`

## Requirements
- R1: After reset `div_out` equals INT_RST (64 by default), `cfg_err` is 0, and the active fraction is 0.
- R2: `div_out` changes only at a clock edge where `tick` is 1, and the new value is visible right after that edge. Without `tick`, a change of controls leaves `div_out` unchanged.
- R3: `int_cfg` and `frac_cfg` are copied into the active settings only at a clock edge where `commit` is 1. Changing them without `commit` has no effect on `div_out`.
- R4: `frac_cfg` is a FRAC_W-bit two's-complement numerator A. Bit FRAC_W-1 is the sign. The fractional ratio is A/2^FRAC_W, which ranges from -0.5 up to just below +0.5.
- R5: In SHAPE, the sum of `div_out` over the 2^FRAC_W ticks that follow a commit differs from int·2^FRAC_W + A by at most 2. This bound also holds over 4·2^FRAC_W ticks.
- R6: In SHAPE, every `div_out` lies within the active integer ±4.
- R7: One cycle after `bypass` is 1, every tick yields exactly the active integer (PASS state).
- R8: One cycle after `dither_en` is 0 with `bypass` 0, every tick yields exactly the active integer (FLAT state).
- R9: At commit, an integer below INT_MIN (25) becomes INT_MIN and one above INT_MAX (100) becomes INT_MAX. `cfg_err` becomes 1 in either case. A legal integer commits unchanged and clears `cfg_err`.
- R10: In SHAPE with A = 0, every tick yields exactly the active integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_cfg | input | INT_W | Integer part from the register file |
| frac_cfg | input | FRAC_W | Signed fraction numerator from the register file |
| commit | input | 1 | Pulse: the top fraction byte has been written; take new settings |
| bypass | input | 1 | 1 = skip the modulator, output the integer |
| dither_en | input | 1 | 0 = treat the fraction as zero |
| tick | input | 1 | One pulse per comparison-clock period |
| div_out | output | INT_W+1 | Divide value for the current period |
| cfg_err | output | 1 | Last committed integer was out of range and was clamped |

## Verification
The bench keeps INT_W at 7 and the legal window at 25 to 100, but builds the block with FRAC_W = 10. A full fractional period is then 1024 ticks, so whole-period sums for positive, negative, extreme-negative (-0.5) and near-maximum fractions, plus a four-period run, fit in a short simulation. The narrower fraction exercises the same carry and sign handling as the 18-bit default. It also makes the sum bound of R5 an exact integer comparison.

// File: rtl/frac_mod_pkg.sv
package frac_mod_pkg;

    typedef enum logic [1:0] {
        MODE_SHAPE = 2'd0,
        MODE_FLAT  = 2'd1,
        MODE_PASS  = 2'd2
    } mod_state_t;

    localparam int NUM_STAGES = 3;

endpackage

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
    parameter int INT_W   = 7,
    parameter int FRAC_W  = 18,
    parameter int INT_MIN = 25,
    parameter int INT_MAX = 100,
    parameter int INT_RST = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [INT_W-1:0]  int_cfg,
    input  logic [FRAC_W-1:0] frac_cfg,
    output logic [INT_W-1:0]  int_act,
    output logic [FRAC_W-1:0] frac_act,
    output logic              cfg_err
);
    localparam logic [INT_W-1:0] LO  = INT_W'(INT_MIN);
    localparam logic [INT_W-1:0] HI  = INT_W'(INT_MAX);
    localparam logic [INT_W-1:0] RST = INT_W'(INT_RST);

    logic [INT_W-1:0] int_clamped;
    logic             too_low, too_high;

    always_comb begin
        too_low  = int_cfg < LO;
        too_high = int_cfg > HI;
        if (too_low)       int_clamped = LO;
        else if (too_high) int_clamped = HI;
        else               int_clamped = int_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_act  <= RST;
            frac_act <= '0;
            cfg_err  <= 1'b0;
        end else if (commit) begin
            int_act  <= int_clamped;
            frac_act <= frac_cfg;
            cfg_err  <= too_low | too_high;
        end
    end
endmodule

// File: rtl/mash_acc.sv
module mash_acc #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] in_val,
    output logic         carry,
    output logic [W-1:0] resid
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, in_val};
        carry = sum[W];
        resid = sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (en)  acc_q <= resid;
    end
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [2:0]        carries,
    output logic signed [3:0] corr
);
    logic c2_d, c3_d, c3_dd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else if (clr) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else if (en) begin
            c2_d  <= carries[1];
            c3_d  <= carries[2];
            c3_dd <= c3_d;
        end
    end

    // first stage as is, second stage first-differenced, third stage second-differenced
    always_comb begin
        corr = $signed({3'b000, carries[0]})
             + $signed({3'b000, carries[1]}) - $signed({3'b000, c2_d})
             + $signed({3'b000, carries[2]}) - $signed({2'b00, c3_d, 1'b0})
             + $signed({3'b000, c3_dd});
    end
endmodule

// File: rtl/frac_ratio_mod.sv
module frac_ratio_mod
    import frac_mod_pkg::*;
#(
    parameter int INT_W   = 7,
    parameter int FRAC_W  = 18,
    parameter int INT_MIN = 25,
    parameter int INT_MAX = 100,
    parameter int INT_RST = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_cfg,
    input  logic [FRAC_W-1:0] frac_cfg,
    input  logic              commit,
    input  logic              bypass,
    input  logic              dither_en,
    input  logic              tick,
    output logic [INT_W:0]    div_out,
    output logic              cfg_err
);
    localparam int SW = INT_W + 2;

    mod_state_t mode_q, mode_d;

    logic [INT_W-1:0]  int_act;
    logic [FRAC_W-1:0] frac_act;
    logic              acc_clr, acc_en;
    logic [FRAC_W-1:0] chain [NUM_STAGES+1];
    logic [NUM_STAGES-1:0] carries;
    logic signed [3:0] corr;
    logic signed [SW-1:0] base_s, shaped_s;
    logic [INT_W:0]    div_q;
    logic              unused_tail;

    cfg_shadow #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .INT_MIN(INT_MIN),
        .INT_MAX(INT_MAX), .INT_RST(INT_RST)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .int_cfg(int_cfg), .frac_cfg(frac_cfg),
        .int_act(int_act), .frac_act(frac_act), .cfg_err(cfg_err)
    );

    // mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SHAPE;
        else        mode_q <= mode_d;
    end

    // next mode: the same controls decide from every state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SHAPE, MODE_FLAT, MODE_PASS: begin
                if (bypass)          mode_d = MODE_PASS;
                else if (!dither_en) mode_d = MODE_FLAT;
                else                 mode_d = MODE_SHAPE;
            end
            default: mode_d = MODE_SHAPE;
        endcase
    end

    assign acc_clr = commit || (mode_q != MODE_SHAPE);
    assign acc_en  = tick && (mode_q == MODE_SHAPE);

    // unsigned view of the signed numerator; the sign moves into the base
    assign chain[0] = frac_act;

    generate
        for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
            mash_acc #(.W(FRAC_W)) u_acc (
                .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
                .in_val(chain[k]), .carry(carries[k]), .resid(chain[k+1])
            );
        end
    endgenerate

    assign unused_tail = ^chain[NUM_STAGES];

    mash_cancel u_cancel (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
        .carries(carries), .corr(corr)
    );

    always_comb begin
        base_s   = $signed({2'b00, int_act})
                 - $signed({{(SW-1){1'b0}}, frac_act[FRAC_W-1]});
        shaped_s = base_s + {{(SW-4){corr[3]}}, corr};
    end

    // output register: updated once per tick according to mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= (INT_W+1)'(INT_RST);
        end else if (tick) begin
            unique case (mode_q)
                MODE_SHAPE: div_q <= shaped_s[INT_W:0];
                MODE_FLAT:  div_q <= {1'b0, int_act};
                MODE_PASS:  div_q <= {1'b0, int_act};
                default:    div_q <= {1'b0, int_act};
            endcase
        end
    end

    assign div_out = div_q;
endmodule

// File: rtl/frac_ratio_mod_chk.sv
module frac_ratio_mod_chk #(
    parameter int INT_W   = 7,
    parameter int INT_MIN = 25,
    parameter int INT_MAX = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             commit,
    input logic [INT_W-1:0] int_cfg,
    input logic [1:0]       mode_q,
    input logic [INT_W-1:0] int_act,
    input logic [INT_W:0]   div_out,
    input logic             cfg_err
);
    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(div_out));

    // R6
    shape_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_q == 2'(frac_mod_pkg::MODE_SHAPE)) |=>
        (int'(div_out) + 4 >= int'($past(int_act)) &&
         int'(div_out) <= int'($past(int_act)) + 4));

    // R7
    pass_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_q == 2'(frac_mod_pkg::MODE_PASS)) |=>
        (int'(div_out) == int'($past(int_act))));

    // R9
    clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (int'(int_cfg) < INT_MIN || int'(int_cfg) > INT_MAX)) |=> cfg_err);

    // R9
    legal_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(int_act) >= INT_MIN && int'(int_act) <= INT_MAX) || int_act == $past(int_act));
endmodule

bind frac_ratio_mod frac_ratio_mod_chk #(
    .INT_W(INT_W), .INT_MIN(INT_MIN), .INT_MAX(INT_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit),
    .int_cfg(int_cfg), .mode_q(mode_q), .int_act(int_act),
    .div_out(div_out), .cfg_err(cfg_err)
);

// File: tb/tb_frac_ratio_mod.sv
module tb_frac_ratio_mod;
    localparam int INT_W  = 7;
    localparam int FRAC_W = 10;
    localparam int N      = 1 << FRAC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [INT_W-1:0]  int_cfg = '0;
    logic [FRAC_W-1:0] frac_cfg = '0;
    logic commit = 1'b0, bypass = 1'b0, dither_en = 1'b1, tick = 1'b0;
    logic [INT_W:0] div_out;
    logic cfg_err;

    frac_ratio_mod #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
        .clk(clk), .rst_n(rst_n), .int_cfg(int_cfg), .frac_cfg(frac_cfg),
        .commit(commit), .bypass(bypass), .dither_en(dither_en), .tick(tick),
        .div_out(div_out), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    typedef struct { int lo; int hi; string tag; } exp_t;
    exp_t sb[$];
    int n_chk = 0, n_bad = 0;
    longint run_sum = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item for each tick the design sees
    always @(posedge clk) begin
        if (rst_n && tick) begin
            #1;
            if (sb.size() == 0) begin
                chk(1'b0, "scoreboard-empty", div_out, -1);
            end else begin
                exp_t it;
                it = sb.pop_front();
                chk(int'(div_out) >= it.lo && int'(div_out) <= it.hi, it.tag,
                    div_out, it.lo);
            end
            run_sum += div_out;
        end
    end

    task automatic drive_tick(input int lo, input int hi, input string tag);
        exp_t it;
        @(negedge clk);
        tick = 1'b1;
        it.lo = lo; it.hi = hi; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic end_ticks();
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_commit(input int iv, input int fv);
        @(negedge clk);
        int_cfg = INT_W'(iv);
        frac_cfg = FRAC_W'(fv);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    // one or more whole fractional periods in SHAPE, checking range and sum
    task automatic shape_run(input int iv, input int fv, input int periods, input string tag);
        longint exp_sum, diff;
        do_commit(iv, fv);
        run_sum = 0;
        for (int i = 0; i < periods * N; i++) drive_tick(iv - 4, iv + 4, "R6 range");
        end_ticks();
        exp_sum = longint'(periods) * (longint'(iv) * N + fv);
        diff = run_sum - exp_sum;
        chk(diff >= -2 && diff <= 2, tag, run_sum, exp_sum);
    endtask

    initial begin
        logic [INT_W:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(div_out == 64, "R1 div_out after reset", div_out, 64);
        chk(cfg_err == 1'b0, "R1 cfg_err after reset", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) drive_tick(64, 64, "R1 zero fraction after reset");
        end_ticks();

        // R10 zero fraction, exact integer each tick
        do_commit(50, 0);
        for (int i = 0; i < 16; i++) drive_tick(50, 50, "R10 zero fraction exact");
        end_ticks();

        // R3 settings change without commit has no effect
        @(negedge clk);
        int_cfg = 7'd70;
        frac_cfg = 10'd300;
        for (int i = 0; i < 16; i++) drive_tick(50, 50, "R3 no commit no effect");
        end_ticks();

        // R4 R5 whole-period averages
        shape_run(41, 256, 1, "R5 sum int41 frac+0.25");
        shape_run(37, -141, 1, "R4 R5 sum int37 negative frac");
        shape_run(60, -512, 1, "R4 R5 sum frac -0.5");
        shape_run(100, 511, 1, "R5 sum int100 near +0.5");
        shape_run(33, 77, 4, "R5 sum four periods");

        // R2 control change without tick leaves output unchanged
        held = div_out;
        @(negedge clk);
        bypass = 1'b1;
        repeat (3) @(negedge clk);
        chk(div_out == held, "R2 no tick no change", div_out, held);

        // R7 bypass gives exact integer
        do_commit(45, 300);
        for (int i = 0; i < 32; i++) drive_tick(45, 45, "R7 bypass exact");
        end_ticks();

        // R8 dither off gives exact integer
        @(negedge clk);
        bypass = 1'b0;
        dither_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 32; i++) drive_tick(45, 45, "R8 dither off exact");
        end_ticks();
        dither_en = 1'b1;
        @(negedge clk);

        // R9 clamping and flag
        do_commit(10, 0);
        chk(cfg_err == 1'b1, "R9 flag low clamp", cfg_err, 1);
        for (int i = 0; i < 4; i++) drive_tick(25, 25, "R9 clamp to 25");
        end_ticks();
        do_commit(120, 0);
        chk(cfg_err == 1'b1, "R9 flag high clamp", cfg_err, 1);
        for (int i = 0; i < 4; i++) drive_tick(100, 100, "R9 clamp to 100");
        end_ticks();
        do_commit(100, 0);
        chk(cfg_err == 1'b0, "R9 flag cleared by legal commit", cfg_err, 0);
        for (int i = 0; i < 4; i++) drive_tick(100, 100, "R9 legal 100 kept");
        end_ticks();

        chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule